// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Controller

This block sits beside a UART receive FIFO and decides when the host should be interrupted. It does not store data. It watches the fill count that the FIFO reports, the push strobe from the deserializer, the pop strobe from the host read port and a one-cycle bit-period tick. From these it derives two interrupt causes.

The first cause is data-available. It holds while the fill count is at or above a trigger level, and the trigger level is picked by a two-bit selector. The second cause is character-timeout. It catches bytes left below the trigger level. It fires once data has been held in the FIFO for four whole character times with no push and no pop. One character time is the programmed frame length in bits, counted in bit ticks. Either strobe restarts the interval, and so does an empty FIFO.

The block drives a single interrupt line and a prioritized identification code, and each cause has its own enable input. With a trigger level of one, the data-available cause holds as long as any byte remains. A host that reads one byte per interrupt therefore drains the FIFO at full speed and never waits for the timeout.

Top module: `uart_rx_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `irq_id` is 3'b001 (nothing pending), and the timeout interval starts from zero.
- R2: `trig_sel` picks the trigger level: 2'b00 gives 1 byte, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. The data-available cause is active in the same cycle that `fifo_count` is at or above that level, and inactive one byte below it.
- R3: With level 1, the data-available cause stays active through every pop that leaves the FIFO non-empty, and it clears only when `fifo_count` reaches 0.
- R4: The timeout cause becomes active on the clock edge that samples the (4 × `frame_bits`)-th `bit_tick` with no push or pop since the interval began, provided `fifo_count` is non-zero. It is inactive one tick earlier.
- R5: A push or a pop sampled at a clock edge restarts the interval from zero and clears an active timeout cause from that edge onward.
- R6: While `fifo_count` is 0 the timeout cause is inactive. An edge sampled with an empty FIFO also restarts the interval.
- R7: `irq_id` is 3'b100 for data-available and 3'b110 for timeout. Data-available wins when both are active. The code is 3'b001 when no enabled cause is active.
- R8: A cause whose enable input is 0 appears neither in `irq_id` nor on `irq`. `irq` is 1 exactly when an enabled cause is active.
- R9: Once reached, the timeout count saturates. Further bit ticks keep the timeout cause active and do not wrap it off.
- R10: Clock cycles without `bit_tick` do not advance the timeout interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | A received byte enters the FIFO this cycle |
| rx_pop | input | 1 | The host reads a byte this cycle |
| fifo_count | input | CNT_W | Current FIFO fill count |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| trig_sel | input | 2 | Trigger level selector |
| frame_bits | input | FRAME_W | Bits per character frame (start, data, parity, stop) |
| en_avail | input | 1 | Enable for the data-available cause |
| en_tmo | input | 1 | Enable for the timeout cause |
| irq | output | 1 | Interrupt request |
| irq_id | output | 3 | Highest-priority pending cause |

## Verification
Suppose the interval counter holds a wrong value, for example one that was not restarted by a strobe, or one that wrapped after saturating. Then the timeout code appears one or more ticks too early or too late, or it drops while data is still waiting. The bench exposes this by checking the exact tick on which the code changes. A faulty threshold decode or a faulty priority stage shows up in the very cycle the fill count crosses the level, because that path is combinational. A broken enable shows as `irq` high while `irq_id` reads nothing pending.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;

   typedef enum logic [2:0] {
      IRQ_ID_NONE  = 3'b001,
      IRQ_ID_AVAIL = 3'b100,
      IRQ_ID_TMO   = 3'b110
   } irq_id_t;

   typedef enum logic [1:0] {
      TRIG_1  = 2'b00,
      TRIG_4  = 2'b01,
      TRIG_8  = 2'b10,
      TRIG_14 = 2'b11
   } trig_sel_t;

   localparam int unsigned TRIG_MAX = 14;

   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         TRIG_1:  return 1;
         TRIG_4:  return 4;
         TRIG_8:  return 8;
         default: return TRIG_MAX;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_trig_decode.sv
module uart_rx_trig_decode
   import uart_rx_irq_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic [1:0]       trig_sel,
   input  logic [CNT_W-1:0] fifo_count,
   output logic [CNT_W-1:0] level,
   output logic             avail
);

   initial begin
      if (CNT_W < $clog2(TRIG_MAX + 1))
         $error("CNT_W too narrow for the largest trigger level");
   end

   always_comb begin
      level = CNT_W'(trig_level(trig_sel));
      avail = (fifo_count >= level);
   end

endmodule

// File: rtl/uart_rx_char_timer.sv
module uart_rx_char_timer #(
   parameter int unsigned FRAME_W    = 4,
   parameter int unsigned TMO_FRAMES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               bit_tick,
   input  logic [FRAME_W-1:0] frame_bits,
   output logic               expired
);

   localparam int unsigned FC_W = $clog2(TMO_FRAMES + 1);
   localparam logic [FC_W-1:0] FC_LIMIT = FC_W'(TMO_FRAMES);

   initial begin
      if (FRAME_W < 1)    $error("FRAME_W must be at least 1");
      if (TMO_FRAMES < 1) $error("TMO_FRAMES must be at least 1");
   end

   logic [FRAME_W-1:0] bit_cnt;
   logic [FC_W-1:0]    frame_cnt;
   logic               frame_end;
   logic               at_limit;

   always_comb begin
      at_limit  = (frame_cnt == FC_LIMIT);
      frame_end = ({1'b0, bit_cnt} + 1'b1) >= {1'b0, frame_bits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         frame_cnt <= '0;
      end else if (restart) begin
         bit_cnt   <= '0;
         frame_cnt <= '0;
      end else if (bit_tick && !at_limit) begin
         if (frame_end) begin
            bit_cnt   <= '0;
            frame_cnt <= frame_cnt + 1'b1;
         end else begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign expired = at_limit;

   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_cnt <= FC_LIMIT);

   a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (frame_cnt == '0 && bit_cnt == '0));

   a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !bit_tick) |=> $stable(frame_cnt));

   a_r9_expired_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !restart) |=> expired);

endmodule

// File: rtl/uart_rx_irq_prio.sv
module uart_rx_irq_prio
   import uart_rx_irq_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       avail,
   input  logic       tmo,
   input  logic       en_avail,
   input  logic       en_tmo,
   output logic       irq,
   output logic [2:0] irq_id
);

   logic    avail_q;
   logic    tmo_q;
   irq_id_t id_next;

   always_comb begin
      avail_q = avail && en_avail;
      tmo_q   = tmo && en_tmo;
      if (avail_q)    id_next = IRQ_ID_AVAIL;
      else if (tmo_q) id_next = IRQ_ID_TMO;
      else            id_next = IRQ_ID_NONE;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [2:0] id_r;
         logic       irq_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_r  <= IRQ_ID_NONE;
               irq_r <= 1'b0;
            end else begin
               id_r  <= id_next;
               irq_r <= avail_q || tmo_q;
            end
         end
         assign irq_id = id_r;
         assign irq    = irq_r;
      end else begin : g_comb
         assign irq_id = id_next;
         assign irq    = avail_q || tmo_q;
      end
   endgenerate

   a_r7_known_code: assert property (@(posedge clk) disable iff (!rst_n)
      irq_id == IRQ_ID_NONE || irq_id == IRQ_ID_AVAIL || irq_id == IRQ_ID_TMO);

endmodule

// File: rtl/uart_rx_irq_ctrl.sv
module uart_rx_irq_ctrl
   import uart_rx_irq_pkg::*;
#(
   parameter int unsigned CNT_W      = 5,
   parameter int unsigned FRAME_W    = 4,
   parameter int unsigned TMO_FRAMES = 4,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_push,
   input  logic               rx_pop,
   input  logic [CNT_W-1:0]   fifo_count,
   input  logic               bit_tick,
   input  logic [1:0]         trig_sel,
   input  logic [FRAME_W-1:0] frame_bits,
   input  logic               en_avail,
   input  logic               en_tmo,
   output logic               irq,
   output logic [2:0]         irq_id
);

   logic [CNT_W-1:0] level;
   logic             avail;
   logic             fifo_empty;
   logic             restart;
   logic             expired;
   logic             tmo;

   assign fifo_empty = (fifo_count == '0);
   assign restart    = rx_push || rx_pop || fifo_empty;
   assign tmo        = expired && !fifo_empty;

   uart_rx_trig_decode #(.CNT_W(CNT_W)) i_decode (
      .trig_sel   (trig_sel),
      .fifo_count (fifo_count),
      .level      (level),
      .avail      (avail)
   );

   uart_rx_char_timer #(.FRAME_W(FRAME_W), .TMO_FRAMES(TMO_FRAMES)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .bit_tick   (bit_tick),
      .frame_bits (frame_bits),
      .expired    (expired)
   );

   uart_rx_irq_prio #(.OUT_REG(OUT_REG)) i_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .avail    (avail),
      .tmo      (tmo),
      .en_avail (en_avail),
      .en_tmo   (en_tmo),
      .irq      (irq),
      .irq_id   (irq_id)
   );

   generate
      if (!OUT_REG) begin : g_chk
         a_r6_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_empty |-> (irq_id == IRQ_ID_NONE && !irq));

         a_r8_irq_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (irq_id != IRQ_ID_NONE));

         a_r7_avail_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (en_avail && avail) |-> irq_id == IRQ_ID_AVAIL);

         a_r5_activity_ends_tmo: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_push || rx_pop) |=> irq_id != IRQ_ID_TMO);
      end
   endgenerate

endmodule

// File: tb/test_uart_rx_irq_ctrl.sv
module test_uart_rx_irq_ctrl;

   localparam int CNT_W   = 5;
   localparam int FRAME_W = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               rx_push = 1'b0;
   logic               rx_pop = 1'b0;
   logic [CNT_W-1:0]   fifo_count = '0;
   logic               bit_tick = 1'b0;
   logic [1:0]         trig_sel = 2'b00;
   logic [FRAME_W-1:0] frame_bits = 4'd10;
   logic               en_avail = 1'b1;
   logic               en_tmo = 1'b1;
   logic               irq;
   logic [2:0]         irq_id;

   localparam logic [2:0] ID_NONE = 3'b001;
   localparam logic [2:0] ID_DATA = 3'b100;
   localparam logic [2:0] ID_TMO  = 3'b110;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   uart_rx_irq_ctrl i_uart_rx_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
      .fifo_count(fifo_count), .bit_tick(bit_tick), .trig_sel(trig_sel),
      .frame_bits(frame_bits), .en_avail(en_avail), .en_tmo(en_tmo),
      .irq(irq), .irq_id(irq_id)
   );

   task automatic check(input string req, input logic [2:0] exp_id, input logic exp_irq);
      n_checks++;
      if (irq_id !== exp_id || irq !== exp_irq) begin
         n_fail++;
         $display("FAIL %s: irq_id=%b irq=%b expected irq_id=%b irq=%b",
                  req, irq_id, irq, exp_id, exp_irq);
      end
   endtask

   // one clock edge with the given strobes, then strobes cleared
   task automatic step(input logic p, input logic q, input logic t);
      @(negedge clk);
      rx_push = p; rx_pop = q; bit_tick = t;
      @(posedge clk); #1;
      rx_push = 0; rx_pop = 0; bit_tick = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 1);
   endtask

   task automatic t_reset;
      #1;
      check("R1 in reset", ID_NONE, 1'b0);
      @(negedge clk); rst_n = 1; #1;
      check("R1 after reset", ID_NONE, 1'b0);
   endtask

   task automatic t_levels;
      en_tmo = 0;
      for (int s = 0; s < 4; s++) begin
         int lv;
         lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
         trig_sel = 2'(s);
         fifo_count = 5'(lv - 1); #1;
         check("R2 below level", (lv == 1) ? ID_NONE : ID_NONE, 1'b0);
         fifo_count = 5'(lv); #1;
         check("R2 at level", ID_DATA, 1'b1);
      end
      en_tmo = 1;
   endtask

   task automatic t_level_one_drain;
      trig_sel = 2'b00;
      fifo_count = 5'd3; step(1, 0, 0);
      for (int c = 3; c > 1; c--) begin
         step(0, 1, 0); fifo_count = 5'(c - 1); #1;
         check("R3 pop leaves data", ID_DATA, 1'b1);
      end
      step(0, 1, 0); fifo_count = 0; #1;
      check("R3 empty", ID_NONE, 1'b0);
   endtask

   task automatic t_timeout;
      trig_sel = 2'b01; frame_bits = 4'd10;
      fifo_count = 5'd3; step(1, 0, 0);
      ticks(39);
      check("R4 one tick early", ID_NONE, 1'b0);
      ticks(1);
      check("R4 timeout fires", ID_TMO, 1'b1);
      ticks(25);
      check("R9 saturated", ID_TMO, 1'b1);
      fifo_count = 5'd4; #1;
      check("R7 data wins", ID_DATA, 1'b1);
      step(1, 0, 0); fifo_count = 5'd3; #1;
      check("R5 push restarts", ID_NONE, 1'b0);
      ticks(39);
      check("R5 interval from zero", ID_NONE, 1'b0);
      step(0, 1, 0); fifo_count = 5'd2; #1;
      check("R5 pop restarts", ID_NONE, 1'b0);
      ticks(40);
      check("R5 fires after pop interval", ID_TMO, 1'b1);
   endtask

   task automatic t_empty_and_idle;
      fifo_count = 0; #1;
      check("R6 empty masks", ID_NONE, 1'b0);
      step(0, 0, 1);
      fifo_count = 5'd2; #1;
      check("R6 empty restarted interval", ID_NONE, 1'b0);
      for (int i = 0; i < 60; i++) step(0, 0, 0);
      check("R10 no ticks no progress", ID_NONE, 1'b0);
      ticks(39);
      check("R10 still one short", ID_NONE, 1'b0);
      ticks(1);
      check("R10 fires on tick count", ID_TMO, 1'b1);
   endtask

   task automatic t_enables;
      en_tmo = 0; #1;
      check("R8 timeout disabled", ID_NONE, 1'b0);
      en_tmo = 1; #1;
      check("R8 timeout re-enabled", ID_TMO, 1'b1);
      en_avail = 0; fifo_count = 5'd6; #1;
      check("R8 data disabled shows timeout", ID_TMO, 1'b1);
      en_tmo = 0; #1;
      check("R8 both disabled", ID_NONE, 1'b0);
      en_avail = 1; #1;
      check("R8 data enabled", ID_DATA, 1'b1);
      en_tmo = 1;
   endtask

   initial begin
      t_reset();
      t_levels();
      t_level_one_drain();
      t_timeout();
      t_empty_and_idle();
      t_enables();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #100000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule